// File: doc/BRIEF.md
# Synchronous-Serial Absolute Position Reader

This block is the controller on the evaluation side of a synchronous-serial absolute-value link. The serial clock line rests high. A start request makes the block issue a burst of clock pulses to the position sensor, starting with a high-to-low edge. On every rising clock edge it takes one bit from the serial data line. It then returns the sensor's position word, MSB first. The sensor's output delay puts a framing "1" on the line at the first rising edge. That bit is dropped, so a frame of DATA_BITS data bits needs DATA_BITS+1 clock pulses. Half a clock period after the last rising edge, the block takes one more sample to check the trailing "0" that the sensor drives after the LSB. The framing bit and the trailing bit together show a broken or shorted line.

When a frame ends, the block pulses a valid strobe for one cycle and reports a line-fault flag. The position output changes only when a frame arrives without a fault. After each frame a minimum pause follows before the next burst can start. This pause should be set to at least twice the sensor's monoflop time. HALF_PERIOD should be chosen so that a whole clock period stays well below the monoflop time, so the sensor does not end the frame early. Any start request that arrives while a frame or pause is in progress is dropped.

The controller has five states. In `ST_IDLE` the clock is high and the block waits for a start request. The transition idle→low is taken when `start_i` is high. In `ST_CLK_LOW` the clock is held low for one half-period. The transition low→high is taken on the half-period tick and samples the data line. In `ST_CLK_HIGH` the clock is held high for one half-period. On the tick the block goes high→low for the next pulse, or, after the final pulse, high→check, which takes the trailing sample. `ST_CHECK` lasts one cycle and judges the frame, then takes check→pause. `ST_PAUSE` holds the line high until the pause timer expires, then takes pause→idle.

Top module: `ssi_reader`

## Requirements
- R1: While `busy_o` is low, `sclk_o` is high. After reset, `sclk_o`=1, `busy_o`=0, `valid_o`=0, `fault_o`=0 and `pos_o`=0.
- R2: A start request accepted in idle produces exactly DATA_BITS+1 falling edges on `sclk_o` before `busy_o` drops again.
- R3: During a frame, each low phase and each inner high phase of `sclk_o` lasts exactly HALF_PERIOD cycles of `clk` (HALF_PERIOD ≥ 2).
- R4: The bit sampled at the first rising edge is discarded. The bits sampled at rising edges 2 to DATA_BITS+1 form `pos_o` from MSB to LSB.
- R5: `fault_o` is set for a frame unless the first sampled bit is 1 and the sample taken one half-period after the last rising edge is 0. On a faulty frame `pos_o` keeps its previous value.
- R6: `valid_o` is high for exactly one cycle per frame. In that same cycle `pos_o` and `fault_o` present the result of the frame.
- R7: `busy_o` stays high through a pause that follows each frame. At least PAUSE_CYCLES cycles pass between the last rising edge of `sclk_o` and the next falling edge. `valid_o` occurs inside this pause.
- R8: `start_i` has no effect while `busy_o` is high, whether a frame or a pause is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request to read one position frame |
| sdata_i | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock to the sensor, resting high |
| pos_o | output | DATA_BITS | Last position word received without a fault |
| valid_o | output | 1 | One-cycle strobe at the end of each frame |
| fault_o | output | 1 | Line-break result of the last frame |
| busy_o | output | 1 | Frame or pause in progress |

## Verification
The main function is driven with every possible 8-bit position word. This exposes any error in bit order, in the offset that drops the framing bit, or in the pulse count. Four damaged line patterns are also applied: data stuck low, data stuck high, a missing framing 1 with otherwise clean data, and a trailing 1 with otherwise clean data. These separate the two halves of the fault rule, and each also checks that the position is held. Some frames carry start requests in the middle of the burst, and start held high during the pause. These show whether a request is wrongly accepted while busy.

// File: rtl/ssi_reader_pkg.sv
package ssi_reader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_CHECK,
        ST_PAUSE
    } ssi_state_e;

endpackage

// File: rtl/ssi_tick_gen.sv
module ssi_tick_gen #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = $clog2(HALF_PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssi_frame_shift.sv
module ssi_frame_shift #(
    parameter int FRAME_BITS = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  shift_i,
    input  logic                  din_i,
    output logic [FRAME_BITS-1:0] frame_o
);
    logic [FRAME_BITS-1:0] frame_q;

    assign frame_o = frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (clr_i) begin
            frame_q <= '0;
        end else if (shift_i) begin
            frame_q <= {frame_q[FRAME_BITS-2:0], din_i};
        end
    end
endmodule

// File: rtl/ssi_pause_timer.sv
module ssi_pause_timer #(
    parameter int PAUSE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int PW = $clog2(PAUSE_CYCLES + 1);

    logic [PW-1:0] cnt_q;

    assign done_o = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= PW'(PAUSE_CYCLES);
        end else if (!done_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/ssi_reader.sv
module ssi_reader
    import ssi_reader_pkg::*;
#(
    parameter int DATA_BITS    = 13,
    parameter int HALF_PERIOD  = 4,
    parameter int PAUSE_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 sdata_i,
    output logic                 sclk_o,
    output logic [DATA_BITS-1:0] pos_o,
    output logic                 valid_o,
    output logic                 fault_o,
    output logic                 busy_o
);
    localparam int FRAME_BITS = DATA_BITS + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(FRAME_BITS);

    ssi_state_e state_q, state_d;

    logic                  tick;
    logic                  pause_done;
    logic                  sample_en;
    logic                  tail_en;
    logic                  last_pulse;
    logic [CNT_W-1:0]      pulse_cnt_q;
    logic                  tail_q;
    logic [FRAME_BITS-1:0] frame;
    logic                  lead_bit;
    logic                  frame_ok;

    logic                 valid_q;
    logic                 fault_q;
    logic [DATA_BITS-1:0] pos_q;

    ssi_tick_gen #(
        .HALF_PERIOD(HALF_PERIOD)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .tick_o(tick)
    );

    ssi_frame_shift #(
        .FRAME_BITS(FRAME_BITS)
    ) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q == ST_IDLE),
        .shift_i(sample_en),
        .din_i  (sdata_i),
        .frame_o(frame)
    );

    ssi_pause_timer #(
        .PAUSE_CYCLES(PAUSE_CYCLES)
    ) i_pause (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(state_q == ST_CHECK),
        .done_o(pause_done)
    );

    assign last_pulse = (pulse_cnt_q == LAST_PULSE);
    assign sample_en  = (state_q == ST_CLK_LOW) && tick;
    assign tail_en    = (state_q == ST_CLK_HIGH) && tick && last_pulse;
    assign lead_bit   = frame[FRAME_BITS-1];
    assign frame_ok   = lead_bit && !tail_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_CLK_LOW;
            ST_CLK_LOW:  if (tick) state_d = ST_CLK_HIGH;
            ST_CLK_HIGH: if (tick) state_d = last_pulse ? ST_CHECK : ST_CLK_LOW;
            ST_CHECK:    state_d = ST_PAUSE;
            ST_PAUSE:    if (pause_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register with frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pulse_cnt_q <= '0;
            tail_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                pulse_cnt_q <= '0;
            end else if (sample_en) begin
                pulse_cnt_q <= pulse_cnt_q + 1'b1;
            end
            if (tail_en) begin
                tail_q <= sdata_i;
            end
        end
    end

    // registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            fault_q <= 1'b0;
            pos_q   <= '0;
        end else begin
            valid_q <= (state_q == ST_CHECK);
            if (state_q == ST_CHECK) begin
                fault_q <= !frame_ok;
                if (frame_ok) begin
                    pos_q <= frame[DATA_BITS-1:0];
                end
            end
        end
    end

    assign sclk_o  = (state_q != ST_CLK_LOW);
    assign busy_o  = (state_q != ST_IDLE);
    assign valid_o = valid_q;
    assign fault_o = fault_q;
    assign pos_o   = pos_q;
endmodule

// File: rtl/ssi_reader_chk.sv
module ssi_reader_chk #(
    parameter int DATA_BITS    = 13,
    parameter int HALF_PERIOD  = 4,
    parameter int PAUSE_CYCLES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 sclk_o,
    input logic [DATA_BITS-1:0] pos_o,
    input logic                 valid_o,
    input logic                 fault_o,
    input logic                 busy_o
);
    localparam int HW = $clog2(PAUSE_CYCLES + HALF_PERIOD + 2);
    localparam logic [HW-1:0] RUN_MAX = HW'(PAUSE_CYCLES + HALF_PERIOD + 1);

    logic [HW-1:0] hi_run_q;
    logic [HW-1:0] lo_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= HW'(PAUSE_CYCLES);
            lo_run_q <= '0;
        end else if (sclk_o) begin
            lo_run_q <= '0;
            if (hi_run_q != RUN_MAX) hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
            if (lo_run_q != RUN_MAX) lo_run_q <= lo_run_q + 1'b1;
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sclk_o); // R1

    AST_LOW_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (lo_run_q == HW'(HALF_PERIOD))); // R3

    AST_MIN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (hi_run_q >= HW'(PAUSE_CYCLES))); // R7

    AST_VALID_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (busy_o && sclk_o)); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6

    AST_POS_HELD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fault_o) |-> $stable(pos_o)); // R5

    AST_START_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R8

    AST_BUSY_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $fell(sclk_o)); // R2
endmodule

bind ssi_reader ssi_reader_chk #(
    .DATA_BITS   (DATA_BITS),
    .HALF_PERIOD (HALF_PERIOD),
    .PAUSE_CYCLES(PAUSE_CYCLES)
) i_ssi_reader_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .sclk_o (sclk_o),
    .pos_o  (pos_o),
    .valid_o(valid_o),
    .fault_o(fault_o),
    .busy_o (busy_o)
);

// File: tb/test_ssi_reader.sv
`timescale 1ns/1ps
module test_ssi_reader;
    localparam int N  = 8;
    localparam int HP = 3;
    localparam int PC = 20;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sdata;
    logic         sclk;
    logic         valid;
    logic         fault;
    logic         busy;
    logic [N-1:0] pos;

    always #2.5 clk = ~clk;

    ssi_reader #(
        .DATA_BITS   (N),
        .HALF_PERIOD (HP),
        .PAUSE_CYCLES(PC)
    ) i_ssi_reader (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .sdata_i(sdata),
        .sclk_o (sclk),
        .pos_o  (pos),
        .valid_o(valid),
        .fault_o(fault),
        .busy_o (busy)
    );

    int n_chk = 0;
    int n_err = 0;

    // sensor model: mode 0 clean, 1 stuck low, 2 stuck high,
    // 3 missing framing one, 4 trailing one after the LSB
    logic [N-1:0] word = '0;
    int           mode = 0;
    int           rcnt = 0;
    logic         sclk_d = 1'b1;

    always @(posedge clk) begin
        sclk_d <= sclk;
        if (!busy && sclk) rcnt <= 0;
        else if (sclk && !sclk_d) rcnt <= rcnt + 1;
    end

    always_comb begin
        if (mode == 1)      sdata = 1'b0;
        else if (mode == 2) sdata = 1'b1;
        else if (rcnt == 0) sdata = (mode != 3);
        else if (rcnt <= N) sdata = word[N-rcnt];
        else                sdata = (mode == 4);
    end

    // line monitor, sampled away from the active edge
    int   falls = 0, half_err = 0, vcnt = 0, lo_run = 0, hi_run = 0, last_gap = 0;
    logic m_prev = 1'b1, m_busy_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sclk && m_prev) begin
                falls++;
                if (!m_busy_prev) last_gap = hi_run;
                else if (hi_run != HP) half_err++;
            end
            if (sclk && !m_prev && lo_run != HP) half_err++;
            if (sclk) begin hi_run++; lo_run = 0; end
            else      begin lo_run++; hi_run = 0; end
            m_prev      = sclk;
            m_busy_prev = busy;
            if (valid) vcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    logic [N-1:0] exp_pos = '0;
    bit           gap_known = 1'b0;

    task automatic run_frame(input logic [N-1:0] w, input int md, input bit poke);
        int f0, h0, v0, t;
        word = w;
        mode = md;
        f0 = falls; h0 = half_err; v0 = vcnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (3*HP) @(negedge clk);
            start = 1'b1;                       // R8 request mid-frame
            @(negedge clk) start = 1'b0;
        end
        t = 0;
        while (!valid && t < 1000) begin @(negedge clk); t++; end
        chk(valid, "R6 valid strobe", valid, 1);
        chk(busy && sclk, "R7 strobe inside pause", busy, 1);
        if (gap_known) chk(last_gap >= PC, "R7 pause length", last_gap, PC);
        if (md == 0) begin
            chk(!fault, "R5 fault clear", fault, 0);
            chk(pos == w, "R4 position word", pos, w);
            exp_pos = w;
        end else begin
            chk(fault, "R5 fault flagged", fault, 1);
            chk(pos == exp_pos, "R5 position held", pos, exp_pos);
        end
        if (poke) begin
            start = 1'b1;                       // R8 request during pause
            repeat (PC/2) @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (busy && t < 1000) begin @(negedge clk); t++; end
        chk(falls - f0 == N+1, "R2 pulse count", falls - f0, N+1);
        chk(half_err == h0, "R3 half-period width", half_err - h0, 0);
        chk(vcnt - v0 == 1, "R6 single strobe", vcnt - v0, 1);
        chk(sclk, "R1 idle line high", sclk, 1);
        if (poke) begin
            f0 = falls;
            repeat (2*PC) @(negedge clk);
            chk(falls == f0 && !busy, "R8 start ignored while busy", falls - f0, 0);
        end
        mode = 0;
        gap_known = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(sclk, "R1 reset clock high", sclk, 1);
        chk(!busy, "R1 reset busy low", busy, 0);
        chk(!valid, "R1 reset valid low", valid, 0);
        chk(!fault, "R1 reset fault low", fault, 0);
        chk(pos == 0, "R1 reset position", pos, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sclk && !busy, "R1 idle after reset", sclk, 1);

        for (int v = 0; v < (1 << N); v++) begin
            run_frame(N'(v), 0, (v % 16) == 5);
        end

        for (int m = 1; m <= 4; m++) begin
            run_frame(N'(8'h3C + m), 0, 1'b0);
            run_frame(N'(8'hA5 - m), m, 1'b0);
        end
        run_frame(N'(8'h81), 0, 1'b0);

        finish_run();
    end
endmodule